// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This unit evaluates one floating-point comparison predicate on two operands that share a format: both single precision or both double precision. It works out whether the pair is less-than, equal or unordered. A 4-bit predicate code selects which of those relations make the one-bit answer true. The answer leaves the unit together with a condition-code slot index that the caller chose from eight, so that the surrounding logic can write the bit into its condition-code field.

The unit also reports an invalid-operation indication. One predicate bit turns any NaN operand into an invalid comparison. A signalling NaN is always invalid, whatever that bit holds. An option compares absolute values: both operands have their sign bits cleared before the ordering is decided.

Each request is a single-cycle strobe. One cycle later the answer, the index, the invalid indication and a done pulse appear together from registers. Updating a status register and raising traps are left to the consumer.

Top module: `fcmp_cond_unit`

## Requirements
- R1: While reset (`rst_n` low) is applied, every output is 0 after the next clock edge.
- R2: `out_done` is 1 in exactly the cycle after a cycle with `in_valid` high, and 0 otherwise. `out_result` and `out_cc` keep their values through cycles without a request, and `out_invalid` is 0 whenever `out_done` is 0.
- R3: The answer is computed as (pred[2] AND less) OR (pred[1] AND equal) OR (pred[0] AND unordered). Less is true only when the operands are not equal. A predicate with bits 2..0 all zero always gives 0.
- R4: When either operand is a NaN, less and equal are both false and unordered is true.
- R5: `out_invalid` is 1 when either operand is a NaN and pred[3] is 1, or when either operand is a signalling NaN, whatever pred[3] holds. A quiet NaN with pred[3] at 0, or two non-NaN operands, give 0.
- R6: When `abs_en` is 1, the sign bits of both non-NaN operands are cleared before the comparison.
- R7: Positive zero and negative zero compare equal and never less.
- R8: Non-NaN values are ordered by sign-magnitude. A negative value is below a positive one. When both operands are negative, the larger magnitude is the smaller value.
- R9: With `fmt_dbl` at 0, only bits 31..0 of each operand are used (sign bit 31, exponent bits 30..23, fraction bits 22..0), and bits 63..32 have no effect. With `fmt_dbl` at 1, all 64 bits are used (sign bit 63, exponent bits 62..52, fraction bits 51..0).
- R10: `out_cc` carries the `cc_sel` value (0 to 7) of the request that `out_result` answers.
- R11: A NaN has an all-ones exponent and a nonzero fraction. It is signalling when the most significant fraction bit is 0. An infinity (all-ones exponent, zero fraction) is an ordinary ordered value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe, one cycle per comparison |
| op_a | input | 64 | First operand (left side of less-than) |
| op_b | input | 64 | Second operand |
| fmt_dbl | input | 1 | 1 = double precision, 0 = single precision in bits 31..0 |
| pred | input | 4 | Predicate code: bit 2 less, bit 1 equal, bit 0 unordered, bit 3 NaN is invalid |
| cc_sel | input | CC_W | Target condition-code index |
| abs_en | input | 1 | Compare absolute values |
| out_result | output | 1 | Registered predicate answer |
| out_cc | output | CC_W | Registered condition-code index |
| out_invalid | output | 1 | Registered invalid-operation indication |
| out_done | output | 1 | Answer strobe, one cycle after the request |

## Verification
On every cycle the assertions check the timing contract: the done pulse follows each request by exactly one cycle, the condition-code index is carried through unchanged, the outputs hold between requests, invalid never appears without done, an empty predicate never answers true, and reset clears everything. The numeric behaviour is shown only by the bench's directed scenarios. These cover sign-magnitude ordering with negative pairs, signed zeros, the absolute-value option, the quiet versus signalling NaN split under both settings of the invalid bit, infinities, and the dependence on the format select, including stray upper bits in single precision.

// File: rtl/fcmp_pkg.sv
`timescale 1ns/1ps
package fcmp_pkg;
   localparam int SGL_EXP_W = 8;
   localparam int SGL_FRC_W = 23;
   localparam int DBL_EXP_W = 11;
   localparam int DBL_FRC_W = 52;
   localparam int SGL_W     = SGL_EXP_W + SGL_FRC_W + 1;
   localparam int DBL_W     = DBL_EXP_W + DBL_FRC_W + 1;
   localparam int MAG_W     = DBL_W - 1;
   localparam int PRED_W    = 4;

   // predicate bit positions
   localparam int PB_UN  = 0;
   localparam int PB_EQ  = 1;
   localparam int PB_LT  = 2;
   localparam int PB_SIG = 3;

   typedef struct packed {
      logic nan;
      logic snan;
      logic zero;
      logic sign;
   } fcls_t;
endpackage

// File: rtl/fcmp_classify.sv
`timescale 1ns/1ps
module fcmp_classify
   import fcmp_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int FRC_W = 23,
   parameter int OUT_W = 63
) (
   input  logic [EXP_W+FRC_W:0] val,
   output fcls_t                cls,
   output logic [OUT_W-1:0]     mag
);
   localparam int VAL_W = EXP_W + FRC_W + 1;

   logic [EXP_W-1:0] expo;
   logic [FRC_W-1:0] frac;
   logic             exp_ones;
   logic             frac_nz;

   assign expo     = val[VAL_W-2 -: EXP_W];
   assign frac     = val[FRC_W-1:0];
   assign exp_ones = &expo;
   assign frac_nz  = |frac;

   always_comb begin
      cls.nan  = exp_ones & frac_nz;
      cls.snan = exp_ones & frac_nz & ~frac[FRC_W-1];
      cls.zero = ~|val[VAL_W-2:0];
      cls.sign = val[VAL_W-1];
   end

   // magnitude widened with zeros keeps its ordering
   generate
      if (OUT_W > VAL_W - 1) begin : g_pad
         assign mag = {{(OUT_W-VAL_W+1){1'b0}}, val[VAL_W-2:0]};
      end else begin : g_direct
         assign mag = val[OUT_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/fcmp_relate.sv
`timescale 1ns/1ps
module fcmp_relate #(
   parameter int MAG_W = 63
) (
   input  logic             sign_a,
   input  logic             sign_b,
   input  logic             zero_a,
   input  logic             zero_b,
   input  logic [MAG_W-1:0] mag_a,
   input  logic [MAG_W-1:0] mag_b,
   output logic             is_eq,
   output logic             is_lt
);
   logic mag_eq;
   logic mag_lt;
   logic lt_raw;

   assign mag_eq = (mag_a == mag_b);
   assign mag_lt = (mag_a < mag_b);

   always_comb begin
      is_eq = (zero_a & zero_b) | ((sign_a == sign_b) & mag_eq);
      unique case ({sign_a, sign_b})
         2'b10:   lt_raw = 1'b1;
         2'b01:   lt_raw = 1'b0;
         2'b00:   lt_raw = mag_lt;
         default: lt_raw = ~mag_lt & ~mag_eq;
      endcase
      is_lt = ~is_eq & lt_raw;
   end
endmodule

// File: rtl/fcmp_cond_unit.sv
`timescale 1ns/1ps
module fcmp_cond_unit
   import fcmp_pkg::*;
#(
   parameter int CC_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DBL_W-1:0]  op_a,
   input  logic [DBL_W-1:0]  op_b,
   input  logic              fmt_dbl,
   input  logic [PRED_W-1:0] pred,
   input  logic [CC_W-1:0]   cc_sel,
   input  logic              abs_en,
   output logic              out_result,
   output logic [CC_W-1:0]   out_cc,
   output logic              out_invalid,
   output logic              out_done
);
   fcls_t            cls_s [2];
   fcls_t            cls_d [2];
   fcls_t            cls_x [2];
   logic [MAG_W-1:0] mag_s [2];
   logic [MAG_W-1:0] mag_d [2];
   logic [MAG_W-1:0] mag_x [2];
   logic             sgn_x [2];

   genvar gi;
   generate
      for (gi = 0; gi < 2; gi++) begin : g_opnd
         logic [DBL_W-1:0] opv;
         assign opv = (gi == 0) ? op_a : op_b;

         fcmp_classify #(.EXP_W(SGL_EXP_W), .FRC_W(SGL_FRC_W), .OUT_W(MAG_W)) u_sgl (
            .val (opv[SGL_W-1:0]),
            .cls (cls_s[gi]),
            .mag (mag_s[gi])
         );

         fcmp_classify #(.EXP_W(DBL_EXP_W), .FRC_W(DBL_FRC_W), .OUT_W(MAG_W)) u_dbl (
            .val (opv),
            .cls (cls_d[gi]),
            .mag (mag_d[gi])
         );

         assign cls_x[gi] = fmt_dbl ? cls_d[gi] : cls_s[gi];
         assign mag_x[gi] = fmt_dbl ? mag_d[gi] : mag_s[gi];
         assign sgn_x[gi] = cls_x[gi].sign & ~abs_en;
      end
   endgenerate

   logic rel_eq;
   logic rel_lt;

   fcmp_relate #(.MAG_W(MAG_W)) u_rel (
      .sign_a (sgn_x[0]),
      .sign_b (sgn_x[1]),
      .zero_a (cls_x[0].zero),
      .zero_b (cls_x[1].zero),
      .mag_a  (mag_x[0]),
      .mag_b  (mag_x[1]),
      .is_eq  (rel_eq),
      .is_lt  (rel_lt)
   );

   logic unord;
   logic any_snan;
   logic lt_q;
   logic eq_q;
   logic ans;
   logic inv;

   always_comb begin
      unord    = cls_x[0].nan | cls_x[1].nan;
      any_snan = cls_x[0].snan | cls_x[1].snan;
      lt_q     = rel_lt & ~unord;
      eq_q     = rel_eq & ~unord;
      ans      = (pred[PB_LT] & lt_q) | (pred[PB_EQ] & eq_q) | (pred[PB_UN] & unord);
      inv      = (unord & pred[PB_SIG]) | any_snan;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_result  <= 1'b0;
         out_cc      <= '0;
         out_invalid <= 1'b0;
         out_done    <= 1'b0;
      end else begin
         out_done    <= in_valid;
         out_invalid <= in_valid & inv;
         if (in_valid) begin
            out_result <= ans;
            out_cc     <= cc_sel;
         end
      end
   end
endmodule

// File: rtl/fcmp_cond_chk.sv
`timescale 1ns/1ps
module fcmp_cond_chk #(
   parameter int CC_W = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic [3:0]      pred,
   input logic [CC_W-1:0] cc_sel,
   input logic            out_result,
   input logic [CC_W-1:0] out_cc,
   input logic            out_invalid,
   input logic            out_done
);
   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> (!out_done && !out_result && !out_invalid && out_cc == '0));

   assert_done_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_done);

   assert_no_stray_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_done);

   assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_result) && $stable(out_cc)));

   assert_inv_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_invalid |-> out_done);

   assert_empty_pred_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && pred[2:0] == 3'b000) |=> !out_result);

   assert_cc_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_cc == $past(cc_sel)));
endmodule

bind fcmp_cond_unit fcmp_cond_chk #(.CC_W(CC_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .pred        (pred),
   .cc_sel      (cc_sel),
   .out_result  (out_result),
   .out_cc      (out_cc),
   .out_invalid (out_invalid),
   .out_done    (out_done)
);

// File: tb/fcmp_cond_unit_tb.sv
`timescale 1ns/1ps
module fcmp_cond_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] op_a = '0;
   logic [63:0] op_b = '0;
   logic        fmt_dbl = 1'b0;
   logic [3:0]  pred = '0;
   logic [2:0]  cc_sel = '0;
   logic        abs_en = 1'b0;
   logic        out_result;
   logic [2:0]  out_cc;
   logic        out_invalid;
   logic        out_done;

   int n_chk = 0;
   int n_bad = 0;
   bit ended = 1'b0;

   always #2 clk = ~clk;

   fcmp_cond_unit #(.CC_W(3)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
      .fmt_dbl(fmt_dbl), .pred(pred), .cc_sel(cc_sel), .abs_en(abs_en),
      .out_result(out_result), .out_cc(out_cc), .out_invalid(out_invalid),
      .out_done(out_done)
   );

   localparam logic [63:0] S_P1   = 64'h3F80_0000;
   localparam logic [63:0] S_P2   = 64'h4000_0000;
   localparam logic [63:0] S_N1   = 64'hBF80_0000;
   localparam logic [63:0] S_N2   = 64'hC000_0000;
   localparam logic [63:0] S_PZ   = 64'h0000_0000;
   localparam logic [63:0] S_NZ   = 64'h8000_0000;
   localparam logic [63:0] S_QNAN = 64'h7FC0_0000;
   localparam logic [63:0] S_NQN  = 64'hFFC0_0000;
   localparam logic [63:0] S_SNAN = 64'h7F80_0001;
   localparam logic [63:0] S_INF  = 64'h7F80_0000;
   localparam logic [63:0] D_P1   = 64'h3FF0_0000_0000_0000;
   localparam logic [63:0] D_P2   = 64'h4000_0000_0000_0000;
   localparam logic [63:0] D_QNAN = 64'h7FF8_0000_0000_0000;
   localparam logic [63:0] D_SNAN = 64'h7FF0_0000_0000_0001;

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic cmp(input logic [63:0] a, input logic [63:0] b, input logic dbl,
                      input logic [3:0] p, input logic [2:0] cc, input logic ab,
                      input logic eres, input logic einv, input string tag);
      @(negedge clk);
      op_a = a; op_b = b; fmt_dbl = dbl; pred = p; cc_sel = cc; abs_en = ab;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk({7'd0, out_done},    8'd1,          {tag, " R2 done"});
      chk({7'd0, out_result},  {7'd0, eres},  {tag, " result"});
      chk({7'd0, out_invalid}, {7'd0, einv},  {tag, " invalid"});
      chk({5'd0, out_cc},      {5'd0, cc},    {tag, " R10 cc"});
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk({7'd0, out_done},    8'd0, "R1 done");
      chk({7'd0, out_result},  8'd0, "R1 result");
      chk({7'd0, out_invalid}, 8'd0, "R1 invalid");
      chk({5'd0, out_cc},      8'd0, "R1 cc");
      rst_n = 1'b1;
   endtask

   task automatic t_predicates;
      cmp(S_P1, S_P2, 0, 4'b0100, 3'd1, 0, 1, 0, "R3 1<2 lt");
      cmp(S_P1, S_P2, 0, 4'b0010, 3'd1, 0, 0, 0, "R3 1<2 eq");
      cmp(S_P1, S_P2, 0, 4'b0110, 3'd1, 0, 1, 0, "R3 1<2 le");
      cmp(S_P1, S_P2, 0, 4'b0001, 3'd1, 0, 0, 0, "R3 1<2 un");
      cmp(S_P2, S_P1, 0, 4'b0100, 3'd1, 0, 0, 0, "R3 2<1 lt");
      cmp(S_P1, S_P1, 0, 4'b0010, 3'd1, 0, 1, 0, "R3 1=1 eq");
      cmp(S_P1, S_P1, 0, 4'b0100, 3'd1, 0, 0, 0, "R3 1=1 lt");
      cmp(S_P1, S_P2, 0, 4'b0000, 3'd1, 0, 0, 0, "R3 empty");
   endtask

   task automatic t_nan;
      cmp(S_QNAN, S_P1, 0, 4'b0001, 3'd2, 0, 1, 0, "R4 qnan un");
      cmp(S_P1, S_QNAN, 0, 4'b0110, 3'd2, 0, 0, 0, "R4 qnan le");
      cmp(S_INF, S_INF, 0, 4'b0010, 3'd2, 0, 1, 0, "R11 inf eq");
      cmp(S_P1, S_INF, 0, 4'b0100, 3'd2, 0, 1, 0, "R11 1<inf");
      cmp(S_INF, S_P1, 0, 4'b0001, 3'd2, 0, 0, 0, "R11 inf ordered");
   endtask

   task automatic t_invalid;
      cmp(S_QNAN, S_P1, 0, 4'b1001, 3'd3, 0, 1, 1, "R5 qnan sig");
      cmp(S_QNAN, S_P1, 0, 4'b0001, 3'd3, 0, 1, 0, "R5 qnan quiet");
      cmp(S_P1, S_SNAN, 0, 4'b0001, 3'd3, 0, 1, 1, "R5 snan quiet");
      cmp(D_SNAN, D_P1, 1, 4'b0110, 3'd3, 0, 0, 1, "R5 dbl snan");
      cmp(D_QNAN, D_P1, 1, 4'b1000, 3'd3, 0, 0, 1, "R5 dbl qnan sig");
      cmp(S_P1, S_P2, 0, 4'b1110, 3'd3, 0, 1, 0, "R5 ordered sig");
   endtask

   task automatic t_zero;
      cmp(S_PZ, S_NZ, 0, 4'b0010, 3'd4, 0, 1, 0, "R7 +0=-0");
      cmp(S_PZ, S_NZ, 0, 4'b0100, 3'd4, 0, 0, 0, "R7 +0<-0");
      cmp(S_NZ, S_PZ, 0, 4'b0100, 3'd4, 0, 0, 0, "R7 -0<+0");
   endtask

   task automatic t_signs;
      cmp(S_N2, S_N1, 0, 4'b0100, 3'd5, 0, 1, 0, "R8 -2<-1");
      cmp(S_N1, S_N2, 0, 4'b0100, 3'd5, 0, 0, 0, "R8 -1<-2");
      cmp(S_N1, S_P1, 0, 4'b0100, 3'd5, 0, 1, 0, "R8 -1<1");
      cmp(S_P1, S_N1, 0, 4'b0100, 3'd5, 0, 0, 0, "R8 1<-1");
   endtask

   task automatic t_abs;
      cmp(S_N2, S_P1, 0, 4'b0100, 3'd6, 0, 1, 0, "R6 -2<1 plain");
      cmp(S_N2, S_P1, 0, 4'b0100, 3'd6, 1, 0, 0, "R6 |-2|<1");
      cmp(S_N1, S_P1, 0, 4'b0010, 3'd6, 1, 1, 0, "R6 |-1|=1");
      cmp(S_NQN, S_P1, 0, 4'b0001, 3'd6, 1, 1, 0, "R6 abs nan un");
   endtask

   task automatic t_format;
      cmp({32'hDEAD_BEEF, S_P1[31:0]}, S_P1, 0, 4'b0010, 3'd7, 0, 1, 0, "R9 sgl upper ignored");
      cmp({32'h7FF0_0000, S_P1[31:0]}, {32'h7FF0_0000, S_P2[31:0]}, 0, 4'b0101, 3'd7, 0, 1, 0,
          "R9 sgl upper nan ignored");
      cmp(D_P1, D_P2, 1, 4'b0100, 3'd7, 0, 1, 0, "R9 dbl 1<2");
      cmp(D_P1, D_P2, 1, 4'b0010, 3'd7, 0, 0, 0, "R9 dbl not eq");
      cmp(D_P1, D_P2, 0, 4'b0010, 3'd7, 0, 1, 0, "R9 low words eq");
   endtask

   task automatic t_cc;
      for (int k = 0; k < 8; k++) begin
         cmp(S_P1, S_P1, 0, 4'b0010, 3'(k), 0, 1, 0, "R10 cc sweep");
      end
   endtask

   task automatic t_idle;
      cmp(S_QNAN, S_P1, 0, 4'b1001, 3'd5, 0, 1, 1, "R2 setup");
      @(negedge clk);
      chk({7'd0, out_done},    8'd0, "R2 idle done");
      chk({7'd0, out_invalid}, 8'd0, "R2 idle invalid");
      chk({7'd0, out_result},  8'd1, "R2 idle result held");
      chk({5'd0, out_cc},      8'd5, "R2 idle cc held");
   endtask

   initial begin
      t_reset();
      t_predicates();
      t_nan();
      t_invalid();
      t_zero();
      t_signs();
      t_abs();
      t_format();
      t_cc();
      t_idle();
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #800000;
      if (!ended) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule